// File: doc/BRIEF.md
# Daisy-Chained Centralized Bus Arbiter

This block decides which of several DMA controllers may take the shared system bus away from the processor, which is the bus owner whenever no controller holds it. Every controller with a pending request contributes to one shared, OR-combined bus-request line. The central arbiter answers that line with a single grant. The grant passes from controller to controller in chain order. A controller that is not requesting passes it on. The first controller that is requesting keeps it, so position 0, the one wired nearest the arbiter, has the highest fixed priority.

A controller holding the grant does not own the bus yet. It waits until the shared busy line reports the bus free. It then takes ownership and keeps the line at its occupied value until it signals completion. The arbiter withdraws the grant once the new owner has taken the bus. It does not grant again until the request line has been seen low or the busy line has been released. This lets the next requester be granted while the current owner is still working, and that requester takes over as soon as the bus frees.

Top module: `bus_grant_chain_arbiter`

## Requirements
- R1: During reset and in the first cycle after it, no controller owns the bus, `grant_o` is 0, `bus_free_o` is 1 and `cpu_own_o` is 1.
- R2: `bus_req_o` is, in the same cycle, the OR over all positions of `req_i[i]` for positions that do not currently own the bus.
- R3: When the arbiter is idle and `bus_req_o` is 1 at a clock edge, `grant_o` is 1 in the next cycle.
- R4: When several controllers request together, the one with the lowest index (index 0 sits nearest the arbiter) becomes the owner.
- R5: A granted requester sets its `own_o` bit at the first clock edge where the grant, its own request and `bus_free_o` are all 1. It never takes the bus in a cycle where `bus_free_o` is 0.
- R6: While a controller owns the bus, a requester that has been granted keeps waiting with `grant_o` still 1 and takes the bus one cycle after the owner releases it.
- R7: An owner keeps `own_o[i]` at 1 until `done_i[i]` is 1 at a clock edge and clears it at that edge. `bus_free_o` is 0 exactly while some controller owns the bus, and `cpu_own_o` equals `bus_free_o`.
- R8: `grant_o` falls at the clock edge where a controller takes ownership. It stays 0 while requests remain pending and the bus stays occupied.
- R9: At most one bit of `own_o` is 1 at any time.
- R10: `done_i[i]` for a position that does not own the bus has no effect on ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_MASTERS | Per-controller bus request, index 0 nearest the arbiter |
| done_i | input | N_MASTERS | Per-controller end-of-tenure strobe |
| bus_req_o | output | 1 | Shared request line (OR of pending requests) |
| grant_o | output | 1 | Grant driven into the head of the chain |
| bus_free_o | output | 1 | Busy line, 1 = free, 0 = occupied |
| cpu_own_o | output | 1 | Processor is the current bus owner |
| own_o | output | N_MASTERS | Per-controller ownership |

## Verification
Simultaneous multi-bit request words tell whether the chain picks the nearest requester and not a farther one (R4). A late request arriving while another controller holds the bus tells whether a granted requester waits for the busy line or takes the bus early (R5, R6). Completion strobes on non-owners tell whether release is tied to the correct position (R10). Long random request and completion streams, checked each cycle against a bench reference, mix these patterns with dropped requests during a grant and back-to-back handovers.

// File: rtl/bga_pkg.sv
package bga_pkg;
   typedef enum logic [1:0] {
      ARB_IDLE  = 2'd0,
      ARB_GRANT = 2'd1,
      ARB_HOLD  = 2'd2
   } arb_state_e;
endpackage

// File: rtl/bga_arbiter_fsm.sv
module bga_arbiter_fsm
   import bga_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic bus_req,
   input  logic bus_free,
   input  logic take_any,
   output logic grant
);
   arb_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ARB_IDLE:  if (bus_req) state_d = ARB_GRANT;
         ARB_GRANT: begin
            if (take_any)      state_d = ARB_HOLD;
            else if (!bus_req) state_d = ARB_IDLE;
         end
         ARB_HOLD:  if (!bus_req || bus_free) state_d = ARB_IDLE;
         default:   state_d = ARB_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ARB_IDLE;
      else        state_q <= state_d;
   end

   assign grant = (state_q == ARB_GRANT);

   AST_GRANT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ARB_IDLE && bus_req) |=> grant);  // R3
   AST_GRANT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      take_any |=> !grant);  // R8
   AST_NO_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ARB_HOLD && bus_req && !bus_free) |=> !grant);  // R8
endmodule

// File: rtl/bga_chain_cell.sv
module bga_chain_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic grant_in,
   input  logic req,
   input  logic done,
   input  logic bus_free,
   output logic grant_out,
   output logic pend,
   output logic take,
   output logic own
);
   logic own_q;

   assign pend      = req & ~own_q;
   assign grant_out = grant_in & ~pend;
   assign take      = grant_in & pend & bus_free;

   always_ff @(posedge clk) begin
      if (!rst_n)          own_q <= 1'b0;
      else if (take)       own_q <= 1'b1;
      else if (done)       own_q <= 1'b0;
   end

   assign own = own_q;

   AST_TAKE_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(own_q) |-> $past(bus_free));  // R5
   AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q && done) |=> !own_q);  // R7
   AST_HOLD_TENURE: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q && !done) |=> own_q);  // R7
endmodule

// File: rtl/bga_busy_line.sv
module bga_busy_line #(
   parameter int N_MASTERS = 4
) (
   input  logic [N_MASTERS-1:0] own,
   output logic                 bus_free,
   output logic                 cpu_own
);
   assign bus_free = ~|own;
   assign cpu_own  = bus_free;
endmodule

// File: rtl/bus_grant_chain_arbiter.sv
module bus_grant_chain_arbiter #(
   parameter int N_MASTERS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_MASTERS-1:0] req_i,
   input  logic [N_MASTERS-1:0] done_i,
   output logic                 bus_req_o,
   output logic                 grant_o,
   output logic                 bus_free_o,
   output logic                 cpu_own_o,
   output logic [N_MASTERS-1:0] own_o
);
   localparam int CHAIN_LEN = N_MASTERS + 1;

   initial begin : param_chk
      assert (N_MASTERS >= 1 && N_MASTERS <= 64)
         else $error("N_MASTERS out of range");
   end

   logic [CHAIN_LEN-1:0] chain_g;
   logic [N_MASTERS-1:0] pend_v, take_v, own_v;
   logic                 bus_free, grant;

   assign chain_g[0] = grant;

   for (genvar i = 0; i < N_MASTERS; i++) begin : g_cell
      bga_chain_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .grant_in  (chain_g[i]),
         .req       (req_i[i]),
         .done      (done_i[i]),
         .bus_free  (bus_free),
         .grant_out (chain_g[i+1]),
         .pend      (pend_v[i]),
         .take      (take_v[i]),
         .own       (own_v[i])
      );
   end

   bga_busy_line #(.N_MASTERS(N_MASTERS)) u_busy (
      .own      (own_v),
      .bus_free (bus_free),
      .cpu_own  (cpu_own_o)
   );

   bga_arbiter_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_req  (|pend_v),
      .bus_free (bus_free),
      .take_any (|take_v),
      .grant    (grant)
   );

   assign bus_req_o  = |pend_v;
   assign grant_o    = grant;
   assign bus_free_o = bus_free;
   assign own_o      = own_v;

   AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(own_v));  // R9
   AST_SINGLE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(take_v) <= 1);  // R4
   AST_FREE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      bus_free_o == (own_o == '0));  // R7
endmodule

// File: tb/bus_grant_chain_arbiter_tb_top.sv
`timescale 1ns/1ps
module bus_grant_chain_arbiter_tb_top;
   localparam int N = 4;
   localparam int S_IDLE = 0, S_GRANT = 1, S_HOLD = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0, done = '0;
   logic         bus_req, grant, bus_free, cpu_own;
   logic [N-1:0] own;

   int n_vec = 0, n_bad = 0;
   int m_st = S_IDLE;
   logic [N-1:0] m_own = '0;

   always #4 clk = ~clk;

   bus_grant_chain_arbiter #(.N_MASTERS(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req), .done_i(done),
      .bus_req_o(bus_req), .grant_o(grant), .bus_free_o(bus_free),
      .cpu_own_o(cpu_own), .own_o(own)
   );

   function automatic logic [N-1:0] lowest_bit(input logic [N-1:0] v);
      for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
      return '0;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input logic [N-1:0] r, input logic [N-1:0] d);
      logic [N-1:0] eff, nxt_own;
      logic breq, free, gnt, take;
      int nxt_st;
      @(negedge clk);
      req = r; done = d;
      #1;
      eff  = r & ~m_own;
      breq = |eff;
      free = (m_own == '0);
      gnt  = (m_st == S_GRANT);
      take = gnt && breq && free;
      check("R2 bus_req", 32'(bus_req), 32'(breq));
      check("R3 grant", 32'(grant), 32'(gnt));
      check("R5 own", 32'(own), 32'(m_own));
      check("R7 bus_free", 32'(bus_free), 32'(free));
      check("R7 cpu_own", 32'(cpu_own), 32'(free));
      nxt_own = m_own & ~d;
      if (take) nxt_own = lowest_bit(eff);
      nxt_st = m_st;
      case (m_st)
         S_IDLE:  if (breq) nxt_st = S_GRANT;
         S_GRANT: if (take) nxt_st = S_HOLD; else if (!breq) nxt_st = S_IDLE;
         default: if (!breq || free) nxt_st = S_IDLE;
      endcase
      @(posedge clk);
      #1;
      m_own = nxt_own;
      m_st  = nxt_st;
   endtask

   initial begin : watchdog
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : stim
      logic [N-1:0] r, d;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      check("R1 own", 32'(own), 32'h0);
      check("R1 grant", 32'(grant), 32'h0);
      check("R1 bus_free", 32'(bus_free), 32'h1);
      check("R1 cpu_own", 32'(cpu_own), 32'h1);
      @(negedge clk); rst_n = 1'b1;

      // R4: simultaneous requests at positions 1 and 3, nearer one wins
      step(4'b1010, '0);
      step(4'b1010, '0);
      check("R4 nearest wins", 32'(own), 32'h2);
      step(4'b1010, '0);
      step(4'b1010, '0);
      check("R8 no regrant while occupied", 32'(grant), 32'h0);
      step(4'b1010, 4'b0010);
      step(4'b1000, '0);
      step(4'b1000, '0);
      step(4'b1000, '0);
      check("R6 handover to next", 32'(own), 32'h8);
      // R6: grant while owner still holds, requester waits for busy release
      step(4'b0000, '0);
      step(4'b0001, '0);
      step(4'b0001, '0);
      check("R6 waiting grant", 32'(grant), 32'h1);
      check("R6 owner kept", 32'(own), 32'h8);
      step(4'b0001, 4'b1000);
      step(4'b0001, '0);
      check("R6 take after release", 32'(own), 32'h1);
      // R10: done on non-owners ignored
      step(4'b0000, 4'b0110);
      check("R10 done ignored", 32'(own), 32'h1);
      step(4'b0000, 4'b0001);
      check("R7 released", 32'(own), 32'h0);
      check("R9 cpu back", 32'(cpu_own), 32'h1);

      // random phase
      r = '0;
      for (int k = 0; k < 4000; k++) begin
         if (($urandom % 4) == 0) r = N'($urandom) & N'($urandom);
         d = N'($urandom) & N'($urandom) & N'($urandom);
         step(r, d);
         check("R9 onehot", 32'($countones(own) <= 1), 32'h1);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule